// File: doc/BRIEF.md
# RS(36,32) Byte-Symbol Decoder with Guided Chip Erasure

This block decodes one 288-bit transfer protected by a Reed-Solomon code over GF(2^8). The transfer is 32 data bytes plus 4 check bytes. Every byte travels on its own data lane, and every four consecutive bytes come from one memory device ("chip"). The block computes four syndromes. It then builds an error locator polynomial and searches all 36 symbol positions for its roots. It applies Forney-style magnitudes and returns the 256 data bits together with a one-hot outcome: clean, corrected or uncorrectable.

Two modes are available. In bounded mode the block repairs any two byte symbols, wherever they lie. In guided chip mode the caller names one chip. The four byte positions of that chip are treated as erasures and solved for directly, so a whole failed device can be repaired. This mode trusts the caller. If the wrong chip is named, the block returns a self-consistent but wrong word and still reports it as corrected.

A 64-byte line takes two passes, one for each 256-bit half. A new request may be issued in the same cycle that the previous result is reported.

Top module: `rs36_dual_decoder`

## Requirements
- R1: Symbol i (0..35) sits in `codeword[8i+7:8i]`. Positions 0..3 hold check bytes and `data_out` is positions 4..35. The field polynomial is x^8+x^4+x^3+x^2+1, and a valid word evaluates to zero at alpha^0..alpha^3 with alpha = 2. A valid word gives `st_clean` and unchanged data.
- R2: In bounded mode, a single corrupted symbol at any position (check or data) is repaired and `st_fixed` is raised.
- R3: In bounded mode, any two corrupted symbols are repaired and `st_fixed` is raised, whether they are adjacent, on the same chip, or far apart.
- R4: In bounded mode, a pattern that no fix of two or fewer symbols can explain raises `st_fail`, and `data_out` then equals the received data bytes unchanged.
- R5: In guided chip mode with `chip_sel` = c (0..8), any corruption confined to positions 4c..4c+3 is repaired with `st_fixed`. A valid word still gives `st_clean`.
- R6: Guided chip mode never raises `st_fail`. If the corruption lies outside the named chip, a wrong word is still returned under `st_fixed`. When chip 0 is named, the returned data equals the received data bytes.
- R7: After reset `done` and all status flags are low. `done` is a one-cycle pulse that goes high 39 cycles after the edge that accepts `start`, and exactly one status flag is high with it.
- R8: A `start` that arrives while a decode is running is ignored. The running result is unaffected and no extra `done` is produced.
- R9: `start` may be asserted in the cycle where `done` is high, so the two halves of a 64-byte line decode back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a decode; accepted only when idle |
| chip_mode | input | 1 | 0: bounded two-symbol mode, 1: guided chip erasure mode |
| chip_sel | input | 4 | Chip whose four symbols are erased in guided mode (0..8) |
| codeword | input | 288 | Received word, symbol i at bits 8i+7:8i |
| done | output | 1 | One-cycle result strobe |
| data_out | output | 256 | Corrected data (symbols 4..35) |
| st_clean | output | 1 | Syndromes were all zero |
| st_fixed | output | 1 | A correction was applied |
| st_fail | output | 1 | Error detected but not correctable |

## Verification
The assertions take for granted that `chip_sel` is in the range 0..8 whenever a guided-mode request is accepted. This is the only input constraint they state, and they check it. Codeword contents are left free, because the word is captured on acceptance. The stimulus names only real chips, and it drives every input on the falling edge. Uncorrectable cases are built from error polynomials whose first three syndromes vanish. These patterns are provably beyond two-symbol repair, so the expected outcome never depends on luck.

// File: rtl/rs36_dual_decoder.sv
module rs36_dual_decoder #(
  parameter int SYMS   = 36,
  parameter int CHECKS = 4,
  parameter int CHIPS  = 9
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         chip_mode,
  input  logic [$clog2(CHIPS)-1:0]     chip_sel,
  input  logic [8*SYMS-1:0]            codeword,
  output logic                         done,
  output logic [8*(SYMS-CHECKS)-1:0]   data_out,
  output logic                         st_clean,
  output logic                         st_fixed,
  output logic                         st_fail
);
  localparam int W  = 8*SYMS;
  localparam int PW = $clog2(SYMS);
  localparam int CW = $clog2(CHIPS);

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00; x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1D : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] ginv(input logic [7:0] a);
    logic [7:0] p, r;
    p = a; r = 8'h01;
    for (int i = 0; i < 7; i++) begin
      p = gmul(p, p);
      r = gmul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] gsyn(input logic [W-1:0] v, input logic [7:0] a);
    logic [7:0] s;
    s = 8'h00;
    for (int i = SYMS-1; i >= 0; i--) s = gmul(s, a) ^ v[8*i +: 8];
    return s;
  endfunction

  typedef enum logic [2:0] {IDLE, SYN, SOLVE, SCAN, FIN} state_t;
  state_t st;

  logic          busy, mode;
  logic [CW-1:0] chip;
  logic [W-1:0]  rx, err;
  logic [7:0]    s [4];
  logic [7:0]    lam [1:4];
  logic [7:0]    om [4];
  logic [2:0]    deg, hits;
  logic          bad;
  logic [PW-1:0] pos;
  logic [7:0]    xi, xinv;

  assign busy     = (st != IDLE);
  assign data_out = rx[W-1:8*CHECKS] ^ err[W-1:8*CHECKS];

  logic [7:0] det, n1, n2, ebeta, ex;
  logic [7:0] elam [5];
  logic [7:0] nlam [1:4];
  logic [7:0] nom [4];
  logic [2:0] ndeg;
  logic       nbad, zero, single;

  assign det    = gmul(s[1], s[1]) ^ gmul(s[0], s[2]);
  assign n1     = gmul(s[2], s[1]) ^ gmul(s[0], s[3]);
  assign n2     = gmul(s[1], s[3]) ^ gmul(s[2], s[2]);
  assign zero   = (s[0] | s[1] | s[2] | s[3]) == 8'h00;
  assign single = (s[0] != 8'h00) && (s[1] != 8'h00) && (gmul(s[2], s[2]) == gmul(s[1], s[3]));

  always_comb begin
    ebeta = 8'h01;
    for (int n = 0; n < CHIPS-1; n++)
      if (n < int'(chip)) ebeta = gmul(ebeta, 8'h10);
    elam[0] = 8'h01;
    for (int d = 1; d < 5; d++) elam[d] = 8'h00;
    ex = ebeta;
    for (int k = 0; k < 4; k++) begin
      for (int d = 4; d >= 1; d--) elam[d] = elam[d] ^ gmul(elam[d-1], ex);
      ex = gmul(ex, 8'h02);
    end
  end

  always_comb begin
    for (int d = 1; d < 5; d++) nlam[d] = 8'h00;
    ndeg = 3'd0;
    nbad = 1'b0;
    if (mode) begin
      for (int d = 1; d < 5; d++) nlam[d] = elam[d];
      ndeg = 3'd4;
    end else if (zero) begin
      ndeg = 3'd0;
    end else if (det != 8'h00) begin
      nlam[1] = gmul(n1, ginv(det));
      nlam[2] = gmul(n2, ginv(det));
      ndeg = 3'd2;
    end else if (single) begin
      nlam[1] = gmul(s[1], ginv(s[0]));
      ndeg = 3'd1;
    end else begin
      nbad = 1'b1;
    end
    nom[0] = s[0];
    nom[1] = s[1] ^ gmul(nlam[1], s[0]);
    nom[2] = s[2] ^ gmul(nlam[1], s[1]) ^ gmul(nlam[2], s[0]);
    nom[3] = s[3] ^ gmul(nlam[1], s[2]) ^ gmul(nlam[2], s[1]) ^ gmul(nlam[3], s[0]);
  end

  logic [7:0] x2, x3, x4, lval, dval, oval, mag;
  logic       hit, fail_w;
  assign x2     = gmul(xinv, xinv);
  assign x3     = gmul(x2, xinv);
  assign x4     = gmul(x2, x2);
  assign lval   = 8'h01 ^ gmul(lam[1], xinv) ^ gmul(lam[2], x2) ^ gmul(lam[3], x3) ^ gmul(lam[4], x4);
  assign dval   = lam[1] ^ gmul(lam[3], x2);
  assign oval   = om[0] ^ gmul(om[1], xinv) ^ gmul(om[2], x2) ^ gmul(om[3], x3);
  assign mag    = gmul(gmul(xi, oval), ginv(dval));
  assign hit    = (lval == 8'h00);
  assign fail_w = !zero && (bad || hits != deg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; done <= 1'b0; st_clean <= 1'b0; st_fixed <= 1'b0; st_fail <= 1'b0;
      mode <= 1'b0; chip <= '0; rx <= '0; err <= '0;
      for (int j = 0; j < 4; j++) begin s[j] <= 8'h00; om[j] <= 8'h00; end
      for (int d = 1; d < 5; d++) lam[d] <= 8'h00;
      deg <= 3'd0; hits <= 3'd0; bad <= 1'b0; pos <= '0; xi <= 8'h01; xinv <= 8'h01;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          rx <= codeword; mode <= chip_mode; chip <= chip_sel; err <= '0; st <= SYN;
        end
        SYN: begin
          for (int j = 0; j < 4; j++) s[j] <= gsyn(rx, 8'(1 << j));
          st <= SOLVE;
        end
        SOLVE: begin
          for (int d = 1; d < 5; d++) lam[d] <= nlam[d];
          for (int j = 0; j < 4; j++) om[j] <= nom[j];
          deg <= ndeg; bad <= nbad; hits <= 3'd0;
          pos <= '0; xi <= 8'h01; xinv <= 8'h01;
          st <= SCAN;
        end
        SCAN: begin
          if (hit) begin
            hits <= hits + 3'd1;
            err[8*pos +: 8] <= mag;
            if (dval == 8'h00) bad <= 1'b1;
          end
          xi   <= gmul(xi, 8'h02);
          xinv <= gmul(xinv, 8'h8E);
          pos  <= pos + 1'b1;
          if (pos == PW'(SYMS-1)) st <= FIN;
        end
        FIN: begin
          done     <= 1'b1;
          st_clean <= zero;
          st_fail  <= fail_w;
          st_fixed <= !zero && !fail_w;
          if (fail_w) err <= '0;
          st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rs36_dual_decoder_chk.sv
module rs36_dual_decoder_chk #(
  parameter int SYMS   = 36,
  parameter int CHECKS = 4,
  parameter int CHIPS  = 9
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start,
  input logic                       chip_mode,
  input logic [$clog2(CHIPS)-1:0]   chip_sel,
  input logic                       done,
  input logic [8*(SYMS-CHECKS)-1:0] data_out,
  input logic                       st_clean,
  input logic                       st_fixed,
  input logic                       st_fail,
  input logic                       busy,
  input logic                       mode,
  input logic [8*SYMS-1:0]          rx
);
  localparam int LAT = SYMS + 3;
  logic [6:0] lat;

  always_ff @(posedge clk) begin
    if (!rst_n) lat <= '0;
    else if (start && !busy) lat <= '0;
    else if (lat != 7'h7F) lat <= lat + 7'd1;
  end

  assert_chip_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && chip_mode |-> int'(chip_sel) < CHIPS);

  assert_done_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_one_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({st_clean, st_fixed, st_fail}) == 1);

  assert_fixed_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> int'(lat) == LAT);

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(rx));

  assert_clean_passes_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done && st_clean |-> data_out == rx[8*SYMS-1:8*CHECKS]);

  assert_fail_passes_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && st_fail |-> data_out == rx[8*SYMS-1:8*CHECKS]);

  assert_guided_never_fails_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode |-> !st_fail);
endmodule

bind rs36_dual_decoder rs36_dual_decoder_chk #(.SYMS(SYMS), .CHECKS(CHECKS), .CHIPS(CHIPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .chip_mode(chip_mode), .chip_sel(chip_sel),
  .done(done), .data_out(data_out), .st_clean(st_clean), .st_fixed(st_fixed),
  .st_fail(st_fail), .busy(busy), .mode(mode), .rx(rx)
);

// File: tb/rs36_dual_decoder_test.sv
module rs36_dual_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] F_CLEAN = 3'b001, F_FIX = 3'b010, F_FAIL = 3'b100;

  logic         clk = 1'b0, rst_n = 1'b0, start = 1'b0, chip_mode = 1'b0;
  logic [3:0]   chip_sel = '0;
  logic [287:0] codeword = '0;
  logic         done, st_clean, st_fixed, st_fail;
  logic [255:0] data_out;

  rs36_dual_decoder uut (
    .clk(clk), .rst_n(rst_n), .start(start), .chip_mode(chip_mode), .chip_sel(chip_sel),
    .codeword(codeword), .done(done), .data_out(data_out),
    .st_clean(st_clean), .st_fixed(st_fixed), .st_fail(st_fail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] gexp [0:509];
  int         glog [0:255];

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    if (a == 0 || b == 0) return 8'h00;
    return gexp[glog[a] + glog[b]];
  endfunction

  function automatic logic [39:0] root_poly(input int n);
    logic [7:0] g [5];
    logic [39:0] r;
    g[0] = 8'h01;
    for (int k = 1; k < 5; k++) g[k] = 8'h00;
    for (int j = 0; j < n; j++)
      for (int k = 4; k >= 0; k--) g[k] = (k > 0 ? g[k-1] : 8'h00) ^ gm(g[k], gexp[j]);
    for (int k = 0; k < 5; k++) r[8*k +: 8] = g[k];
    return r;
  endfunction

  function automatic logic [287:0] encode(input logic [255:0] d);
    logic [7:0] r [36];
    logic [39:0] g;
    logic [7:0] c;
    g = root_poly(4);
    for (int i = 0; i < 4; i++) r[i] = 8'h00;
    for (int i = 4; i < 36; i++) r[i] = d[8*(i-4) +: 8];
    for (int i = 35; i >= 4; i--) begin
      c = r[i];
      for (int k = 0; k < 5; k++) r[i-4+k] = r[i-4+k] ^ gm(c, g[8*k +: 8]);
    end
    return {d, r[3], r[2], r[1], r[0]};
  endfunction

  function automatic logic [287:0] flip(input logic [287:0] cw, input int p, input logic [7:0] v);
    return cw ^ (288'(v) << (8*p));
  endfunction

  function automatic logic [287:0] hard_pattern(input int off, input logic [7:0] scale);
    logic [39:0] e;
    logic [287:0] m;
    e = root_poly(3);
    m = '0;
    for (int k = 0; k < 4; k++) m = flip(m, off + k, gm(scale, e[8*k +: 8]));
    return m;
  endfunction

  logic [255:0] exp_data_q [$];
  logic [2:0]   exp_flag_q [$];
  string        tag_q [$];
  int           t0_q [$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [255:0] act, input logic [255:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done && !finished) begin
      if (exp_data_q.size() == 0) begin
        check(1'b0, "R8", "unexpected done", 256'(1), 256'(0));
      end else begin
        logic [255:0] ed;
        logic [2:0]   ef;
        string        tg;
        int           t0;
        ed = exp_data_q.pop_front();
        ef = exp_flag_q.pop_front();
        tg = tag_q.pop_front();
        t0 = t0_q.pop_front();
        check(data_out == ed, tg, "data", data_out, ed);
        check({st_fail, st_fixed, st_clean} == ef, tg, "status", 256'({st_fail, st_fixed, st_clean}), 256'(ef));
        check(cyc - t0 == 40, "R7", "latency", 256'(cyc - t0), 256'(40));
      end
    end
  end

  task automatic send(input logic [287:0] cw, input logic m, input logic [3:0] c,
                      input logic [255:0] ed, input logic [2:0] ef, input string tag, input bit glitch);
    exp_data_q.push_back(ed);
    exp_flag_q.push_back(ef);
    tag_q.push_back(tag);
    t0_q.push_back(cyc);
    codeword = cw; chip_mode = m; chip_sel = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (glitch) begin
      repeat (10) @(negedge clk);
      codeword = ~cw; chip_mode = ~m; chip_sel = 4'd7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      codeword = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      check(1'b0, "R7", "watchdog expired", 256'(0), 256'(1));
      summary();
    end
  end

  initial begin
    logic [255:0] d0, d1, dlo, dhi;
    logic [287:0] c0, c1, w;
    gexp[0] = 8'h01;
    for (int i = 1; i < 510; i++)
      gexp[i] = {gexp[i-1][6:0], 1'b0} ^ (gexp[i-1][7] ? 8'h1D : 8'h00);
    glog[0] = 0;
    for (int i = 0; i < 255; i++) glog[gexp[i]] = i;

    for (int i = 0; i < 8; i++) begin
      d0[32*i +: 32] = $urandom;
      d1[32*i +: 32] = $urandom;
      dlo[32*i +: 32] = $urandom;
      dhi[32*i +: 32] = $urandom;
    end
    c0 = encode(d0);
    c1 = encode(d1);

    repeat (3) @(negedge clk);
    check(done == 1'b0, "R7", "reset done", 256'(done), 256'(0));
    check({st_fail, st_fixed, st_clean} == 3'b000, "R7", "reset status",
          256'({st_fail, st_fixed, st_clean}), 256'(0));
    rst_n = 1'b1;
    @(negedge clk);

    send(c0, 1'b0, 4'd0, d0, F_CLEAN, "R1", 1'b0);
    send(c1, 1'b0, 4'd0, d1, F_CLEAN, "R1", 1'b0);

    send(flip(c0, 0, 8'h5A), 1'b0, 4'd0, d0, F_FIX, "R2", 1'b0);
    send(flip(c0, 35, 8'hFF), 1'b0, 4'd0, d0, F_FIX, "R2", 1'b0);
    send(flip(c1, 17, 8'h01), 1'b0, 4'd0, d1, F_FIX, "R2", 1'b0);

    send(flip(flip(c0, 12, 8'h3C), 13, 8'hA5), 1'b0, 4'd0, d0, F_FIX, "R3", 1'b0);
    send(flip(flip(c1, 5, 8'h80), 30, 8'h7E), 1'b0, 4'd0, d1, F_FIX, "R3", 1'b0);
    send(flip(flip(c0, 2, 8'h11), 33, 8'hC3), 1'b0, 4'd0, d0, F_FIX, "R3", 1'b0);

    w = c0 ^ hard_pattern(20, 8'h37);
    send(w, 1'b0, 4'd0, w[287:32], F_FAIL, "R4", 1'b0);
    w = c1 ^ hard_pattern(0, 8'h01);
    send(w, 1'b0, 4'd0, w[287:32], F_FAIL, "R4", 1'b0);
    w = c1 ^ hard_pattern(9, 8'hE2);
    send(w, 1'b0, 4'd0, w[287:32], F_FAIL, "R4", 1'b0);

    send(c0 ^ hard_pattern(20, 8'h37), 1'b1, 4'd5, d0, F_FIX, "R5", 1'b0);
    send(c1 ^ hard_pattern(0, 8'h01), 1'b1, 4'd0, d1, F_FIX, "R5", 1'b0);
    w = c0;
    for (int k = 32; k < 36; k++) w = flip(w, k, 8'($urandom_range(1, 255)));
    send(w, 1'b1, 4'd8, d0, F_FIX, "R5", 1'b0);
    send(c1, 1'b1, 4'd4, d1, F_CLEAN, "R5", 1'b0);

    w = flip(flip(c1, 12, 8'h42), 15, 8'h99);
    send(w, 1'b1, 4'd0, w[287:32], F_FIX, "R6", 1'b0);

    send(flip(c1, 7, 8'h6D), 1'b0, 4'd0, d1, F_FIX, "R8", 1'b1);

    send(flip(encode(dlo), 9, 8'h24), 1'b0, 4'd0, dlo, F_FIX, "R9", 1'b0);
    send(flip(flip(encode(dhi), 21, 8'h0F), 22, 8'hF0), 1'b0, 4'd0, dhi, F_FIX, "R9", 1'b0);

    repeat (50) @(negedge clk);
    check(exp_data_q.size() == 0, "R8", "results outstanding",
          256'(exp_data_q.size()), 256'(0));
    summary();
  end
endmodule